// File: doc/BRIEF.md
# Five-Level Page-Table Walker with Intermediate-Pointer Cache

This block resolves a page number into a local physical page by walking a five-level page table held in local memory. It is entered only after every translation buffer in front of it has missed. A request carries the page number and the pointer to the root table. Before it issues any memory read, the walker checks a small 2-way set-associative cache of intermediate table pointers. If that cache holds the table of some deeper level for the same root and the same upper page-number bits, the walk starts at the deepest such level and skips the reads above it.

Each memory read is a single word. The walker has at most one read outstanding and takes the returned entry on a data strobe. A valid leaf entry yields the physical page. An entry whose valid bit is clear ends the walk with a fault that names the level where it occurred. Every valid non-leaf entry that is read is written into the pointer cache, and each set uses least-recently-used replacement. The walker handles one walk at a time.

Top module: `page_walker`

## Requirements
- R1: After reset, req_ready is 1 and busy, rsp_valid and mem_rd_valid are 0, and the pointer cache holds nothing.
- R2: A walk that finds nothing in the cache issues five reads, for levels 0 to 4. The read word address is {table pointer, 9-bit index}. The index for level L is req_vpn[44-9L -: 9], so level 0 takes the most significant slice. Level 0 uses req_root as its pointer. Each valid entry gives the next pointer in bits [24:1], and the level-4 pointer is returned on rsp_ppn with rsp_fault 0.
- R3: Entry bit 0 is the valid bit. An entry with bit 0 clear ends the walk at once: rsp_fault is 1, rsp_fault_level gives the level of that entry, and no further read is issued.
- R4: The cache is checked before the first read. When it holds the table pointer for level k of this walk (1 ≤ k ≤ 4), the walk starts at the deepest such k and issues 5−k reads.
- R5: A cache entry matches only if its level, the page-number bits above that level's slice, and the root pointer are all equal. A different root therefore gives a cold walk.
- R6: Every valid non-leaf entry read at level L is inserted as the level L+1 pointer. An entry with bit 0 clear is never inserted.
- R7: The cache has 2 ways per set. The set for level k is the low 3 bits of the level k−1 index XOR k. A new entry fills an empty way first, and otherwise the least recently used way. Both a lookup hit and an insertion make the way concerned the most recently used one.
- R8: req_ready is high only when no walk is in progress. busy rises in the cycle after a request is accepted and stays high until the response handshake completes.
- R9: While mem_rd_valid is high and mem_rd_ready is low, mem_rd_valid and mem_rd_addr hold. While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_ppn, rsp_fault and rsp_fault_level hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_vpn | input | 45 | Page number to resolve |
| req_root | input | 24 | Root table pointer |
| rsp_valid | output | 1 | Walk result available |
| rsp_ready | input | 1 | Result taken |
| rsp_ppn | output | 24 | Resolved physical page (0 on fault) |
| rsp_fault | output | 1 | Walk ended on an invalid entry |
| rsp_fault_level | output | 3 | Level of the invalid entry |
| mem_rd_valid | output | 1 | Memory read request |
| mem_rd_ready | input | 1 | Memory accepts the read |
| mem_rd_addr | output | 33 | Word address {pointer, index} |
| mem_rdata_valid | input | 1 | Returned entry strobe |
| mem_rdata | input | 32 | Returned page-table entry |
| busy | output | 1 | A walk is in progress |

## Verification
A corrupted tag, level or root in the pointer cache becomes visible on the next walk that shares an upper prefix. The walk then either makes more reads than the deepest valid entry allows, or it starts from a wrong pointer. In the second case the leaf page returned in that same response is wrong. The bench counts reads per walk and compares the count against what R4 and R7 predict. A replacement that picks the wrong way only shows up two or three walks later. For that reason, sequences that fill and then overflow one set on every level are replayed, and the read count of the victim walk is checked. A fault that leaks into the cache turns the retried walk's page number wrong in its first response.

// File: rtl/pw_pkg.sv
package pw_pkg;
    // Default geometry shared by the walker modules.
    localparam int unsigned PW_LEVELS = 5;
    localparam int unsigned PW_IDX_W  = 9;
    localparam int unsigned PW_PPN_W  = 24;
    localparam int unsigned PW_ENT_W  = 32;
    localparam int unsigned PW_SETS   = 8;

    // Walk controller states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_ISSUE,
        ST_WAIT,
        ST_RESP
    } walk_state_e;
endpackage

// File: rtl/pw_index_sel.sv
// Forms the memory word address for the current level.
// Assumes level 0 takes the most significant index slice of the page number.
module pw_index_sel #(
    parameter int unsigned LEVELS = pw_pkg::PW_LEVELS,
    parameter int unsigned IDX_W  = pw_pkg::PW_IDX_W,
    parameter int unsigned PPN_W  = pw_pkg::PW_PPN_W,
    localparam int unsigned VPN_W  = LEVELS * IDX_W,
    localparam int unsigned LVL_W  = $clog2(LEVELS),
    localparam int unsigned ADDR_W = PPN_W + IDX_W
) (
    input  logic [VPN_W-1:0]  vpn,
    input  logic [LVL_W-1:0]  level,
    input  logic [PPN_W-1:0]  table_ptr,
    output logic [ADDR_W-1:0] rd_addr
);
    logic [IDX_W-1:0] slice;

    // Select the index slice that belongs to the current level.
    always_comb begin
        slice = '0;
        for (int l = 0; l < int'(LEVELS); l++) begin
            if (level == LVL_W'(l)) begin
                slice = vpn[int'(VPN_W) - 1 - l * int'(IDX_W) -: IDX_W];
            end
        end
    end

    assign rd_addr = {table_ptr, slice};
endmodule

// File: rtl/pw_walk_cache.sv
// 2-way set-associative cache of intermediate table pointers.
// An entry holds the table pointer for level k (1..LEVELS-1), tagged by
// level, the page-number bits above slice k and the root pointer.
// Lookup compares every cacheable level in parallel and reports the deepest
// hit. Assumes lookup and insert never occur in the same cycle.
module pw_walk_cache #(
    parameter int unsigned LEVELS = pw_pkg::PW_LEVELS,
    parameter int unsigned IDX_W  = pw_pkg::PW_IDX_W,
    parameter int unsigned PPN_W  = pw_pkg::PW_PPN_W,
    parameter int unsigned SETS   = pw_pkg::PW_SETS,
    localparam int unsigned VPN_W = LEVELS * IDX_W,
    localparam int unsigned LVL_W = $clog2(LEVELS),
    localparam int unsigned SET_W = $clog2(SETS),
    localparam int unsigned NLVL  = LEVELS - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_en,
    input  logic [VPN_W-1:0] lk_vpn,
    input  logic [PPN_W-1:0] lk_root,
    output logic             lk_hit,
    output logic [LVL_W-1:0] lk_level,
    output logic [PPN_W-1:0] lk_ptr,
    input  logic             ins_en,
    input  logic [LVL_W-1:0] ins_level,
    input  logic [VPN_W-1:0] ins_vpn,
    input  logic [PPN_W-1:0] ins_root,
    input  logic [PPN_W-1:0] ins_ptr
);
    localparam int unsigned WAYS = 2;

    function automatic logic [VPN_W-1:0] keep_mask(input int unsigned n);
        keep_mask = ~({VPN_W{1'b1}} >> (n * IDX_W));
    endfunction

    logic             e_v    [SETS][WAYS];
    logic [LVL_W-1:0] e_lvl  [SETS][WAYS];
    logic [VPN_W-1:0] e_pfx  [SETS][WAYS];
    logic [PPN_W-1:0] e_root [SETS][WAYS];
    logic [PPN_W-1:0] e_ptr  [SETS][WAYS];
    logic [SETS-1:0]  lru_q;

    logic [SET_W-1:0] lvl_set [NLVL];
    logic [WAYS-1:0]  lvl_hit [NLVL];
    logic [SET_W-1:0] hit_set;
    logic             hit_way;
    logic [SET_W-1:0] ins_set;
    logic [VPN_W-1:0] ins_pfx;
    logic             victim;

    genvar k, w;
    for (k = 1; k < LEVELS; k++) begin : g_lvl
        logic [SET_W-1:0] s;
        logic [VPN_W-1:0] pfx;
        logic [WAYS-1:0]  hit;

        assign pfx = lk_vpn & keep_mask(k);
        assign s   = lk_vpn[VPN_W - k * IDX_W +: SET_W] ^ SET_W'(k);

        for (w = 0; w < WAYS; w++) begin : g_way
            assign hit[w] = e_v[s][w] && (e_lvl[s][w] == LVL_W'(k)) &&
                            (e_pfx[s][w] == pfx) && (e_root[s][w] == lk_root);
        end

        assign lvl_set[k-1] = s;
        assign lvl_hit[k-1] = hit;

        // Inserts never duplicate a tag, so one set cannot hit twice.
        p_single_way_r6: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(hit));
    end

    // Pick the deepest level that hits.
    always_comb begin
        lk_hit   = 1'b0;
        lk_level = '0;
        lk_ptr   = '0;
        hit_set  = '0;
        hit_way  = 1'b0;
        for (int i = 0; i < int'(NLVL); i++) begin
            if (|lvl_hit[i]) begin
                lk_hit   = 1'b1;
                lk_level = LVL_W'(i + 1);
                hit_set  = lvl_set[i];
                hit_way  = lvl_hit[i][1];
                lk_ptr   = e_ptr[lvl_set[i]][lvl_hit[i][1]];
            end
        end
    end

    // Find the set, prefix and victim way for an insertion.
    always_comb begin
        ins_set = '0;
        ins_pfx = '0;
        for (int i = 1; i < int'(LEVELS); i++) begin
            if (ins_level == LVL_W'(i)) begin
                ins_set = ins_vpn[int'(VPN_W) - i * int'(IDX_W) +: SET_W] ^ SET_W'(i);
                ins_pfx = ins_vpn & keep_mask(i);
            end
        end
        if (!e_v[ins_set][0])      victim = 1'b0;
        else if (!e_v[ins_set][1]) victim = 1'b1;
        else                       victim = lru_q[ins_set];
    end

    // Valid bits and replacement state (lru_q names the way to evict next).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < int'(SETS); s++) begin
                for (int v = 0; v < int'(WAYS); v++) e_v[s][v] <= 1'b0;
            end
            lru_q <= '0;
        end else if (ins_en) begin
            e_v[ins_set][victim] <= 1'b1;
            lru_q[ins_set]       <= ~victim;
        end else if (lk_en && lk_hit) begin
            lru_q[hit_set] <= ~hit_way;
        end
    end

    // Entry payload, written on insertion only.
    always_ff @(posedge clk) begin
        if (ins_en) begin
            e_lvl[ins_set][victim]  <= ins_level;
            e_pfx[ins_set][victim]  <= ins_pfx;
            e_root[ins_set][victim] <= ins_root;
            e_ptr[ins_set][victim]  <= ins_ptr;
        end
    end

    p_ins_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ins_en |-> (ins_level != '0) && (ins_level < LVL_W'(LEVELS)));

    p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ins_en && lk_en));
endmodule

// File: rtl/pw_walk_ctrl.sv
// Walk sequencer: accepts a request, consults the pointer cache once,
// then issues one read per level and consumes each returned entry.
// Assumes the memory returns exactly one entry per accepted read.
module pw_walk_ctrl #(
    parameter int unsigned LEVELS = pw_pkg::PW_LEVELS,
    parameter int unsigned IDX_W  = pw_pkg::PW_IDX_W,
    parameter int unsigned PPN_W  = pw_pkg::PW_PPN_W,
    parameter int unsigned ENT_W  = pw_pkg::PW_ENT_W,
    localparam int unsigned VPN_W = LEVELS * IDX_W,
    localparam int unsigned LVL_W = $clog2(LEVELS),
    localparam int unsigned CNT_W = $clog2(LEVELS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [VPN_W-1:0] req_vpn,
    input  logic [PPN_W-1:0] req_root,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [PPN_W-1:0] rsp_ppn,
    output logic             rsp_fault,
    output logic [LVL_W-1:0] rsp_fault_level,
    output logic             mem_rd_valid,
    input  logic             mem_rd_ready,
    input  logic             mem_rdata_valid,
    input  logic [ENT_W-1:0] mem_rdata,
    output logic             busy,
    output logic [VPN_W-1:0] vpn_q,
    output logic [PPN_W-1:0] root_q,
    output logic [LVL_W-1:0] level_q,
    output logic [PPN_W-1:0] ptr_q,
    output logic             lk_en,
    input  logic             lk_hit,
    input  logic [LVL_W-1:0] lk_level,
    input  logic [PPN_W-1:0] lk_ptr,
    output logic             ins_en,
    output logic [LVL_W-1:0] ins_level,
    output logic [PPN_W-1:0] ins_ptr
);
    import pw_pkg::*;

    walk_state_e      state_q;
    logic [CNT_W-1:0] rd_cnt_q;
    logic             ent_ok;
    logic [PPN_W-1:0] ent_ptr;
    logic             at_leaf;

    assign ent_ok  = mem_rdata[0];
    assign ent_ptr = mem_rdata[PPN_W:1];
    assign at_leaf = (level_q == LVL_W'(LEVELS - 1));

    assign req_ready    = (state_q == ST_IDLE);
    assign busy         = (state_q != ST_IDLE);
    assign lk_en        = (state_q == ST_LOOKUP);
    assign mem_rd_valid = (state_q == ST_ISSUE);
    assign rsp_valid    = (state_q == ST_RESP);

    // Insert each valid non-leaf entry as the next level's table pointer.
    always_comb begin
        ins_en    = (state_q == ST_WAIT) && mem_rdata_valid && ent_ok && !at_leaf;
        ins_level = level_q + LVL_W'(1);
        ins_ptr   = ent_ptr;
    end

    // Walk state, current level, pointer and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q         <= ST_IDLE;
            vpn_q           <= '0;
            root_q          <= '0;
            level_q         <= '0;
            ptr_q           <= '0;
            rd_cnt_q        <= '0;
            rsp_ppn         <= '0;
            rsp_fault       <= 1'b0;
            rsp_fault_level <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        vpn_q    <= req_vpn;
                        root_q   <= req_root;
                        rd_cnt_q <= '0;
                        state_q  <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    level_q <= lk_hit ? lk_level : '0;
                    ptr_q   <= lk_hit ? lk_ptr : root_q;
                    state_q <= ST_ISSUE;
                end
                ST_ISSUE: begin
                    if (mem_rd_ready) begin
                        rd_cnt_q <= rd_cnt_q + CNT_W'(1);
                        state_q  <= ST_WAIT;
                    end
                end
                ST_WAIT: begin
                    if (mem_rdata_valid) begin
                        if (!ent_ok) begin
                            rsp_ppn         <= '0;
                            rsp_fault       <= 1'b1;
                            rsp_fault_level <= level_q;
                            state_q         <= ST_RESP;
                        end else if (at_leaf) begin
                            rsp_ppn         <= ent_ptr;
                            rsp_fault       <= 1'b0;
                            rsp_fault_level <= '0;
                            state_q         <= ST_RESP;
                        end else begin
                            level_q <= level_q + LVL_W'(1);
                            ptr_q   <= ent_ptr;
                            state_q <= ST_ISSUE;
                        end
                    end
                end
                ST_RESP: begin
                    if (rsp_ready) state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_ppn) &&
                                    $stable(rsp_fault) && $stable(rsp_fault_level));

    p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> busy && !req_ready);

    p_read_budget_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rd_cnt_q != '0) && (rd_cnt_q <= CNT_W'(LEVELS)));

    p_fault_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault |-> (rsp_fault_level < LVL_W'(LEVELS)) && (rsp_ppn == '0));
endmodule

// File: rtl/page_walker.sv
// Top of the page-table walker: sequencer, pointer cache and address former.
// Assumes one read outstanding at most and a responder that returns one
// entry per accepted read.
module page_walker #(
    parameter int unsigned LEVELS = pw_pkg::PW_LEVELS,
    parameter int unsigned IDX_W  = pw_pkg::PW_IDX_W,
    parameter int unsigned PPN_W  = pw_pkg::PW_PPN_W,
    parameter int unsigned ENT_W  = pw_pkg::PW_ENT_W,
    parameter int unsigned SETS   = pw_pkg::PW_SETS,
    localparam int unsigned VPN_W  = LEVELS * IDX_W,
    localparam int unsigned LVL_W  = $clog2(LEVELS),
    localparam int unsigned ADDR_W = PPN_W + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [VPN_W-1:0]  req_vpn,
    input  logic [PPN_W-1:0]  req_root,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [PPN_W-1:0]  rsp_ppn,
    output logic              rsp_fault,
    output logic [LVL_W-1:0]  rsp_fault_level,
    output logic              mem_rd_valid,
    input  logic              mem_rd_ready,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rdata_valid,
    input  logic [ENT_W-1:0]  mem_rdata,
    output logic              busy
);
    logic [VPN_W-1:0] vpn_q;
    logic [PPN_W-1:0] root_q;
    logic [LVL_W-1:0] level_q;
    logic [PPN_W-1:0] ptr_q;
    logic             lk_en;
    logic             lk_hit;
    logic [LVL_W-1:0] lk_level;
    logic [PPN_W-1:0] lk_ptr;
    logic             ins_en;
    logic [LVL_W-1:0] ins_level;
    logic [PPN_W-1:0] ins_ptr;

    pw_walk_ctrl #(
        .LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W), .ENT_W(ENT_W)
    ) i_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_root(req_root),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_ppn(rsp_ppn), .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata),
        .busy(busy),
        .vpn_q(vpn_q), .root_q(root_q), .level_q(level_q), .ptr_q(ptr_q),
        .lk_en(lk_en), .lk_hit(lk_hit), .lk_level(lk_level), .lk_ptr(lk_ptr),
        .ins_en(ins_en), .ins_level(ins_level), .ins_ptr(ins_ptr)
    );

    pw_walk_cache #(
        .LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W), .SETS(SETS)
    ) i_cache (
        .clk(clk), .rst_n(rst_n),
        .lk_en(lk_en), .lk_vpn(vpn_q), .lk_root(root_q),
        .lk_hit(lk_hit), .lk_level(lk_level), .lk_ptr(lk_ptr),
        .ins_en(ins_en), .ins_level(ins_level), .ins_vpn(vpn_q),
        .ins_root(root_q), .ins_ptr(ins_ptr)
    );

    pw_index_sel #(
        .LEVELS(LEVELS), .IDX_W(IDX_W), .PPN_W(PPN_W)
    ) i_index (
        .vpn(vpn_q), .level(level_q), .table_ptr(ptr_q), .rd_addr(mem_rd_addr)
    );

    p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid && !mem_rd_ready |=> mem_rd_valid && $stable(mem_rd_addr));

    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_valid && !rsp_valid);
endmodule

// File: tb/test_page_walker.sv
module test_page_walker;
    localparam int unsigned PPN_W  = 24;
    localparam int unsigned VPN_W  = 45;
    localparam int unsigned ADDR_W = 33;

    typedef struct {
        logic [PPN_W-1:0] ppn;
        logic             fault;
        logic [2:0]       flvl;
        int               reads;
        string            tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [VPN_W-1:0]  req_vpn = '0;
    logic [PPN_W-1:0]  req_root = '0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [PPN_W-1:0]  rsp_ppn;
    logic              rsp_fault;
    logic [2:0]        rsp_fault_level;
    logic              mem_rd_valid;
    logic              mem_rd_ready = 1'b0;
    logic [ADDR_W-1:0] mem_rd_addr;
    logic              mem_rdata_valid = 1'b0;
    logic [31:0]       mem_rdata = '0;
    logic              busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int walk_reads = 0;
    exp_t sb[$];

    logic              fault_on = 1'b0;
    logic [ADDR_W-1:0] fault_addr = '0;

    always #2 clk = ~clk;

    page_walker i_page_walker (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_vpn(req_vpn), .req_root(req_root),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_ppn(rsp_ppn), .rsp_fault(rsp_fault), .rsp_fault_level(rsp_fault_level),
        .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready),
        .mem_rd_addr(mem_rd_addr),
        .mem_rdata_valid(mem_rdata_valid), .mem_rdata(mem_rdata),
        .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Page-table contents: a fixed hash of the word address, valid unless marked faulty.
    function automatic logic [31:0] entry_of(input logic [ADDR_W-1:0] a);
        logic [63:0] h;
        h = {31'd0, a} * 64'h9E37_79B1 ^ 64'h5A5A5;
        if (fault_on && a == fault_addr) return {h[40:17], 8'h00};
        return {7'd0, h[40:17], 1'b1};
    endfunction

    function automatic logic [VPN_W-1:0] mk_vpn(input logic [8:0] i0, i1, i2, i3, i4);
        return {i0, i1, i2, i3, i4};
    endfunction

    // Address read at level lv on a clean table.
    function automatic logic [ADDR_W-1:0] addr_at(input logic [VPN_W-1:0] v,
                                                  input logic [PPN_W-1:0] root, input int lv);
        logic [PPN_W-1:0] p;
        logic [31:0] e;
        p = root;
        for (int l = 0; l < lv; l++) begin
            e = entry_of({p, v[44 - 9*l -: 9]});
            p = e[24:1];
        end
        return {p, v[44 - 9*lv -: 9]};
    endfunction

    // Memory responder: ready pattern, two-cycle data latency.
    logic              rd_pend = 1'b0;
    int                rd_wait = 0;
    logic [ADDR_W-1:0] rd_a = '0;
    always @(negedge clk) begin
        cyc++;
        mem_rdata_valid = 1'b0;
        if (rd_pend) begin
            rd_wait--;
            if (rd_wait == 0) begin
                mem_rdata_valid = 1'b1;
                mem_rdata       = entry_of(rd_a);
                rd_pend         = 1'b0;
            end
        end
        mem_rd_ready = (cyc % 3 != 1);
        if (rst_n && mem_rd_valid && mem_rd_ready) begin
            rd_a    = mem_rd_addr;
            rd_pend = 1'b1;
            rd_wait = 2;
            walk_reads++;
        end
    end

    // Monitor: hold responses two cycles, check they stay put, then compare.
    int hold = 0;
    logic [PPN_W-1:0] held_ppn;
    logic held_fault;
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (hold == 0) begin
                held_ppn = rsp_ppn;
                held_fault = rsp_fault;
            end
            if (hold < 2) begin
                rsp_ready = 1'b0;
                if (hold > 0)
                    chk(rsp_ppn == held_ppn && rsp_fault == held_fault,
                        "R9 response held under backpressure", rsp_ppn, held_ppn);
                hold++;
            end else begin
                exp_t e;
                rsp_ready = 1'b1;
                hold = 0;
                if (sb.size() == 0) begin
                    chk(1'b0, "R8 unexpected response", rsp_ppn, 0);
                end else begin
                    e = sb.pop_front();
                    chk(rsp_fault == e.fault, {e.tag, " fault flag"}, rsp_fault, e.fault);
                    chk(rsp_ppn == e.ppn, {e.tag, " page"}, rsp_ppn, e.ppn);
                    if (e.fault)
                        chk(rsp_fault_level == e.flvl, {e.tag, " fault level"},
                            rsp_fault_level, e.flvl);
                    chk(walk_reads == e.reads, {e.tag, " read count"}, walk_reads, e.reads);
                end
                walk_reads = 0;
            end
        end else begin
            rsp_ready = 1'b0;
        end
    end

    // Driver: compute the expected result, push it, issue the request, wait for it.
    task automatic walk(input logic [VPN_W-1:0] v, input logic [PPN_W-1:0] root,
                        input int reads, input string tag);
        exp_t e;
        logic [PPN_W-1:0] p;
        logic [31:0] ent;
        p = root;
        e.fault = 1'b0;
        e.flvl = '0;
        e.ppn = '0;
        for (int l = 0; l < 5; l++) begin
            ent = entry_of({p, v[44 - 9*l -: 9]});
            if (!ent[0]) begin
                e.fault = 1'b1;
                e.flvl = 3'(l);
                break;
            end
            p = ent[24:1];
        end
        if (!e.fault) e.ppn = p;
        e.reads = reads;
        e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
        req_vpn = v;
        req_root = root;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy && !req_ready, "R8 busy after accept", {busy, req_ready}, 2'b10);
        wait (sb.size() == 0);
        @(negedge clk);
        chk(!busy && req_ready, "R8 idle after response", {busy, req_ready}, 2'b01);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [VPN_W-1:0] va, vb, vc, vd, vx;
        repeat (3) @(negedge clk);
        chk(req_ready && !busy && !rsp_valid && !mem_rd_valid, "R1 reset state",
            {req_ready, busy, rsp_valid, mem_rd_valid}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !busy, "R1 idle after reset", {req_ready, busy}, 2'b10);

        va = mk_vpn(9'h1A3, 9'h045, 9'h10F, 9'h0C2, 9'h077);
        walk(va, 24'h00_1234, 5, "R2 cold walk");
        walk(va, 24'h00_1234, 1, "R4 leaf pointer cached");
        vx = mk_vpn(9'h1A3, 9'h045, 9'h10F, 9'h005, 9'h1FF);
        walk(vx, 24'h00_1234, 2, "R4 resume at level 3");
        walk(va, 24'h00_5678, 5, "R5 other root misses");
        vx = mk_vpn(9'h0E1, 9'h045, 9'h10F, 9'h0C2, 9'h077);
        walk(vx, 24'h00_1234, 5, "R5 other top prefix misses");

        vd = mk_vpn(9'h033, 9'h122, 9'h0AB, 9'h19C, 9'h006);
        fault_addr = addr_at(vd, 24'h00_0BEE, 2);
        fault_on = 1'b1;
        walk(vd, 24'h00_0BEE, 3, "R3 fault at level 2");
        fault_on = 1'b0;
        walk(vd, 24'h00_0BEE, 3, "R6 retry starts at level 2");
        fault_addr = addr_at(vd, 24'h00_0BEE, 4);
        fault_on = 1'b1;
        walk(vd, 24'h00_0BEE, 1, "R3 fault at leaf");
        fault_on = 1'b0;

        do_reset();
        chk(req_ready && !busy, "R1 idle after second reset", {req_ready, busy}, 2'b10);
        walk(va, 24'h00_1234, 5, "R1 cache emptied by reset");

        do_reset();
        va = mk_vpn(9'h008, 9'h000, 9'h000, 9'h000, 9'h000);
        vb = mk_vpn(9'h010, 9'h000, 9'h000, 9'h000, 9'h000);
        vc = mk_vpn(9'h018, 9'h000, 9'h000, 9'h000, 9'h000);
        walk(va, 24'h00_0100, 5, "R7 fill way A");
        walk(vb, 24'h00_0100, 5, "R7 fill way B");
        walk(va, 24'h00_0100, 1, "R7 hit touches A");
        walk(vc, 24'h00_0100, 5, "R7 third walk evicts");
        walk(va, 24'h00_0100, 1, "R7 recently used survives");
        walk(vb, 24'h00_0100, 2, "R7 LRU victim at leaf level");

        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule